// File: doc/BRIEF.md
# Multi-Cycle Bus Transfer Sequencer

This block sits on the master side of a 32-bit processor bus. It takes one internal request of 1, 2, 4, 8 or 16 bytes from the core and runs it as a sequence of bus transfers. For each transfer it presents a dword address and four byte-lane enables. It drives an active-low "final transfer" flag and ends with a one-clock done pulse to the core.

The number of transfers is not known when a request is accepted. The system returns three sizing replies: a cacheability reply, an 8-bit port reply and a 16-bit port reply, all active low. The block takes these from the clock before the first ready of the request and fixes its transfer plan when that ready completes. Narrow ports split the request into byte or halfword pieces. A cacheable read on a full-width port grows into a four-dword line fill. The fill visits the dwords of the line in an order made by XORing the starting dword index with the beat number.

Each transfer ends with one of two readies. The single ready closes the bus cycle, so the next transfer opens a new address phase. The burst ready keeps the bus cycle open, so the next transfer's address appears in the very next clock.

Top module: `bus_xfer_seq`

## Requirements
- R1: In idle, an asserted `req_valid_i` is taken at a clock edge. The size code 0,1,2,3,4 means 1,2,4,8,16 bytes. The next clock is a one-clock address phase with `cyc_start_o` high and `busy_o` high. It shows the dword address of the request start, and lane i is enabled for the request bytes whose address bits [1:0] equal i.
- R2: Each clock of a data phase registers the three sizing replies. The plan is decoded from the values present one clock before the completing ready, so values that change in the ready clock itself have no effect. The plan is then fixed for the rest of the request.
- R3: `last_xfer_n_o` is high in every address-phase clock, in the first data clock of every bus cycle, and whenever the block is idle.
- R4: From the second data clock of a bus cycle onward, `last_xfer_n_o` is low exactly while the current transfer is the final one of the request.
- R5: A ready given in the first data clock of a bus cycle is ignored. The transfer and its address stay in place.
- R6: With `port8_n_i` low, each transfer after the first moves one byte. With only `port16_n_i` low, each moves two bytes. The 8-bit reply wins when both are low. The transfer count is the number of port-width-aligned pieces the request touches. The first transfer's lanes cover all request bytes in its dword, because the width is not yet known.
- R7: On a 32-bit port, a request that crosses a dword boundary splits into one transfer per dword touched.
- R8: A read answered as cacheable on a 32-bit port becomes four transfers of the 16-byte line. They run at dword indices start^0, start^1, start^2, start^3 (a start at offset 4 gives 4, 0, C, 8), and transfers after the first enable all four lanes.
- R9: A write is never turned into a line fill, whatever the cacheability reply.
- R10: A burst ready on a non-final transfer keeps the bus cycle open. The next transfer's address shows in the next clock with no address phase, and it may complete in that clock.
- R11: A single ready on a non-final transfer closes the bus cycle, and the next transfer starts with a new address phase. When both readies are low, the single ready wins.
- R12: A line fill whose bus cycle is closed by a single ready carries on in the same line order in the new bus cycle.
- R13: In the clock after the ready of the final transfer, `done_o` is high for one clock and `busy_o` is low, and a new request can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Core request strobe, taken only while idle |
| req_addr_i | input | AW | Byte address of the request start |
| req_size_i | input | 3 | Size code, bytes = 1 << code (0..4) |
| req_write_i | input | 1 | High for a write request |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-clock pulse after the final transfer |
| cyc_start_o | output | 1 | Address phase of a bus cycle |
| xfer_addr_o | output | AW | Dword address of the current transfer |
| lane_en_o | output | 4 | Byte-lane enables of the current transfer |
| last_xfer_n_o | output | 1 | Active-low final-transfer flag |
| cache_ok_n_i | input | 1 | Active-low cacheability reply |
| port8_n_i | input | 1 | Active-low 8-bit port reply |
| port16_n_i | input | 1 | Active-low 16-bit port reply |
| ack_n_i | input | 1 | Active-low single ready |
| burst_ack_n_i | input | 1 | Active-low burst ready |

## Verification
The assertions assume several things about the inputs. Requests arrive only while the block is idle and carry a size code of at most 4. A request never runs past the top of the address space. The system gives a ready only after the sizing replies have been stable for a clock. The stimulus keeps to these limits. Each request is issued only after the previous done pulse, at low addresses. The sizing replies are held for the whole request, except in the one case that moves them during the ready clock to show they are not used. One test deliberately gives a ready in the first data clock to show it is ignored.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;

    localparam int unsigned LANES       = 4;
    localparam int unsigned LANE_W      = $clog2(LANES);
    localparam int unsigned LINE_BEATS  = 4;
    localparam int unsigned BEAT_W      = $clog2(LINE_BEATS);
    localparam int unsigned LINE_OFF_W  = LANE_W + BEAT_W;
    localparam int unsigned SIZE_W      = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    // value equals log2 of bytes moved per transfer
    typedef enum logic [1:0] {
        PW_8  = 2'd0,
        PW_16 = 2'd1,
        PW_32 = 2'd2
    } port_width_e;

    typedef struct packed {
        logic        cache_ok_n;
        logic        port8_n;
        logic        port16_n;
    } resp_t;

    typedef struct packed {
        logic        fill;
        port_width_e width;
    } plan_t;

    function automatic plan_t decode_plan(input resp_t r, input logic is_write);
        plan_t p;
        if (!r.port8_n)       p.width = PW_8;
        else if (!r.port16_n) p.width = PW_16;
        else                  p.width = PW_32;
        p.fill = !r.cache_ok_n && !is_write && (p.width == PW_32);
        return p;
    endfunction

endpackage

// File: rtl/bxs_resp_sample.sv
module bxs_resp_sample
    import bus_xfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sample_en,
    input  logic  clear,
    input  resp_t resp_i,
    output resp_t resp_o,
    output logic  valid_o
);

    resp_t resp_q;
    logic  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q  <= '1;
            valid_q <= 1'b0;
        end else begin
            if (sample_en) resp_q <= resp_i;
            if (clear)          valid_q <= 1'b0;
            else if (sample_en) valid_q <= 1'b1;
        end
    end

    assign resp_o  = resp_q;
    assign valid_o = valid_q;

    AST_CLEAR_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        clear |=> !valid_o); // R3

    AST_SAMPLE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !clear) |=> valid_o); // R5

endmodule

// File: rtl/bxs_progress.sv
module bxs_progress
    import bus_xfer_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [AW-1:0]     addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              advance,
    input  logic              fill_i,
    input  port_width_e       width_i,
    output logic [AW-1:0]     ptr_o,
    output logic [AW-1:0]     end_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              last_o
);

    logic [AW-1:0]     ptr_q, end_q, ptr_nxt;
    logic [BEAT_W-1:0] beat_q;
    logic [1:0]        k;

    assign k       = width_i;
    assign ptr_nxt = ((ptr_q >> k) + AW'(1)) << k;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            end_q  <= '0;
            beat_q <= '0;
        end else if (load) begin
            ptr_q  <= addr_i;
            end_q  <= addr_i + (AW'(1) << size_i) - AW'(1);
            beat_q <= '0;
        end else if (advance) begin
            beat_q <= beat_q + BEAT_W'(1);
            if (!fill_i) ptr_q <= ptr_nxt;
        end
    end

    always_comb begin
        if (fill_i) last_o = (beat_q == BEAT_W'(LINE_BEATS - 1));
        else        last_o = ((ptr_q >> k) == (end_q >> k));
    end

    assign ptr_o  = ptr_q;
    assign end_o  = end_q;
    assign beat_o = beat_q;

    AST_FILL_BEAT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (advance && fill_i) |-> (beat_q != BEAT_W'(LINE_BEATS - 1))); // R8

    AST_PTR_WITHIN_REQ: assert property (@(posedge clk) disable iff (rst)
        (advance && !fill_i) |=> (ptr_q <= end_q)); // R6

endmodule

// File: rtl/bxs_lane_gen.sv
module bxs_lane_gen
    import bus_xfer_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0]     ptr_i,
    input  logic [AW-1:0]     end_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              fill_i,
    input  port_width_e       width_i,
    output logic [AW-1:0]     addr_o,
    output logic [LANES-1:0]  lanes_o
);

    logic [1:0]    kl;
    logic [AW-1:0] mask, piece_end, hi;

    assign kl        = width_i;
    assign mask      = (AW'(1) << kl) - AW'(1);
    assign piece_end = ptr_i | mask;
    assign hi        = (piece_end > end_i) ? end_i : piece_end;

    logic [LANES-1:0] span;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [AW-1:0] byte_addr;
        assign byte_addr = {ptr_i[AW-1:LANE_W], LANE_W'(i)};
        assign span[i]   = (byte_addr >= ptr_i) && (byte_addr <= hi);
    end

    always_comb begin
        if (fill_i) begin
            addr_o  = {ptr_i[AW-1:LINE_OFF_W],
                       ptr_i[LINE_OFF_W-1:LANE_W] ^ beat_i,
                       {LANE_W{1'b0}}};
            lanes_o = '1;
        end else begin
            addr_o  = {ptr_i[AW-1:LANE_W], {LANE_W{1'b0}}};
            lanes_o = span;
        end
    end

endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq
    import bus_xfer_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [AW-1:0]     req_addr_i,
    input  logic [SIZE_W-1:0] req_size_i,
    input  logic              req_write_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cyc_start_o,
    output logic [AW-1:0]     xfer_addr_o,
    output logic [LANES-1:0]  lane_en_o,
    output logic              last_xfer_n_o,
    input  logic              cache_ok_n_i,
    input  logic              port8_n_i,
    input  logic              port16_n_i,
    input  logic              ack_n_i,
    input  logic              burst_ack_n_i
);

    seq_state_e        state_q, state_d;
    plan_t             plan_q, plan_now;
    logic              locked_q, write_q, done_q;
    resp_t             resp_in, resp_q;
    logic              resp_vld;
    logic              in_data, ack_any, ack_seen, single_ack;
    logic              load, advance, is_last;
    logic [AW-1:0]     ptr, end_addr;
    logic [BEAT_W-1:0] beat;
    port_width_e       lane_w;
    logic              lane_fill;

    always_comb begin
        resp_in.cache_ok_n = cache_ok_n_i;
        resp_in.port8_n    = port8_n_i;
        resp_in.port16_n   = port16_n_i;
    end

    assign in_data    = (state_q == ST_DATA);
    assign ack_any    = !ack_n_i || !burst_ack_n_i;
    assign single_ack = !ack_n_i;
    assign ack_seen   = in_data && resp_vld && ack_any;
    assign load       = (state_q == ST_IDLE) && req_valid_i;
    assign plan_now   = locked_q ? plan_q : decode_plan(resp_q, write_q);
    assign advance    = ack_seen && !is_last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid_i) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: begin
                if (ack_seen) begin
                    if (is_last)         state_d = ST_IDLE;
                    else if (single_ack) state_d = ST_ADDR;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            plan_q   <= '0;
            locked_q <= 1'b0;
            write_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ack_seen && is_last;
            if (load) begin
                write_q  <= req_write_i;
                locked_q <= 1'b0;
            end else if (ack_seen && !locked_q) begin
                locked_q <= 1'b1;
                plan_q   <= plan_now;
            end
        end
    end

    bxs_resp_sample u_resp (
        .clk       (clk),
        .rst       (rst),
        .sample_en (in_data),
        .clear     (state_q == ST_ADDR),
        .resp_i    (resp_in),
        .resp_o    (resp_q),
        .valid_o   (resp_vld)
    );

    bxs_progress #(.AW(AW)) u_prog (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .addr_i  (req_addr_i),
        .size_i  (req_size_i),
        .advance (advance),
        .fill_i  (plan_now.fill),
        .width_i (plan_now.width),
        .ptr_o   (ptr),
        .end_o   (end_addr),
        .beat_o  (beat),
        .last_o  (is_last)
    );

    assign lane_w    = locked_q ? plan_q.width : PW_32;
    assign lane_fill = locked_q && plan_q.fill;

    bxs_lane_gen #(.AW(AW)) u_lanes (
        .ptr_i   (ptr),
        .end_i   (end_addr),
        .beat_i  (beat),
        .fill_i  (lane_fill),
        .width_i (lane_w),
        .addr_o  (xfer_addr_o),
        .lanes_o (lane_en_o)
    );

    assign busy_o        = (state_q != ST_IDLE);
    assign cyc_start_o   = (state_q == ST_ADDR);
    assign last_xfer_n_o = !(in_data && resp_vld && is_last);
    assign done_o        = done_q;

    AST_ADDR_PHASE_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
        cyc_start_o |-> last_xfer_n_o); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (last_xfer_n_o && !cyc_start_o)); // R3

    AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(!last_xfer_n_o && (!ack_n_i || !burst_ack_n_i))); // R13

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R13

    AST_EARLY_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (in_data && !resp_vld && ack_any) |=> (busy_o && !cyc_start_o && !done_o)); // R5

    AST_BURST_KEEPS_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (ack_seen && ack_n_i && last_xfer_n_o) |=> (busy_o && !cyc_start_o)); // R10

    AST_SINGLE_REOPENS: assert property (@(posedge clk) disable iff (rst)
        (ack_seen && !ack_n_i && last_xfer_n_o) |=> cyc_start_o); // R11

    AST_FILL_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (busy_o && locked_q && plan_q.fill) |-> (lane_en_o == '1)); // R8

    AST_LANES_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        in_data |-> (lane_en_o != '0)); // R6

    AST_WRITE_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        (busy_o && locked_q && write_q) |-> !plan_q.fill); // R9

endmodule

// File: tb/bus_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module bus_xfer_seq_tb_top;
    import bus_xfer_pkg::*;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic          busy, done, cyc_start, last_n;
    logic [AW-1:0] xaddr;
    logic [3:0]    lanes;
    logic          cache_ok_n = 1'b1, port8_n = 1'b1, port16_n = 1'b1;
    logic          ack_n = 1'b1, burst_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_xfer_seq #(.AW(AW)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid_i   (req_valid),
        .req_addr_i    (req_addr),
        .req_size_i    (req_size),
        .req_write_i   (req_write),
        .busy_o        (busy),
        .done_o        (done),
        .cyc_start_o   (cyc_start),
        .xfer_addr_o   (xaddr),
        .lane_en_o     (lanes),
        .last_xfer_n_o (last_n),
        .cache_ok_n_i  (cache_ok_n),
        .port8_n_i     (port8_n),
        .port16_n_i    (port16_n),
        .ack_n_i       (ack_n),
        .burst_ack_n_i (burst_n)
    );

    task automatic chk_eq(input string rq, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Runs one request against a model built from the requirements.
    task automatic run_xact(input logic [31:0] a, input logic [2:0] sz, input bit wr,
                            input bit cn, input bit w8n, input bit w16n,
                            input logic [7:0] burst_m, input bit both_low,
                            input bit early, input bit flip, input string rq);
        bit          fill;
        int          k, n;
        logic [31:0] e, p;
        bit          new_cyc;
        fill    = !cn && !wr && w8n && w16n;
        k       = !w8n ? 0 : (!w16n ? 1 : 2);
        e       = a + (32'd1 << sz) - 32'd1;
        n       = fill ? 4 : (int'((e >> k) - (a >> k)) + 1);
        p       = a;
        new_cyc = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        cache_ok_n = cn; port8_n = w8n; port16_n = w16n;
        ack_n = 1'b1; burst_n = 1'b1;
        for (int t = 0; t < n; t++) begin
            logic [31:0] ea, hi;
            logic [3:0]  eb;
            int          wl;
            wl = (t == 0) ? 2 : k;
            hi = p | ((32'd1 << wl) - 32'd1);
            if (hi > e) hi = e;
            for (int i = 0; i < 4; i++) begin
                logic [31:0] b;
                b = {p[31:2], 2'(i)};
                eb[i] = (b >= p) && (b <= hi);
            end
            if (fill) begin
                ea = {a[31:4], a[3:2] ^ 2'(t), 2'b00};
                if (t > 0) eb = 4'hF;
            end else begin
                ea = {p[31:2], 2'b00};
            end
            @(negedge clk);
            req_valid = 1'b0; ack_n = 1'b1; burst_n = 1'b1;
            if (new_cyc) begin
                chk_eq({rq, " R1/R11 addr phase"}, "cyc_start", 32'(cyc_start), 32'd1);
                chk_eq({rq, " R1 addr phase"}, "busy", 32'(busy), 32'd1);
                chk_eq({rq, " R1 addr phase"}, "addr", xaddr, ea);
                chk_eq({rq, " R1 addr phase"}, "lanes", 32'(lanes), 32'(eb));
                chk_eq({rq, " R3 addr phase"}, "last_n", 32'(last_n), 32'd1);
                @(negedge clk);
                chk_eq({rq, " R3 first data clk"}, "last_n", 32'(last_n), 32'd1);
                chk_eq({rq, " R3 first data clk"}, "cyc_start", 32'(cyc_start), 32'd0);
                if (early && t == 0) begin
                    ack_n = 1'b0;
                    @(negedge clk);
                    ack_n = 1'b1;
                    chk_eq({rq, " R5 early ack"}, "addr held", xaddr, ea);
                    chk_eq({rq, " R5 early ack"}, "cyc_start", 32'(cyc_start), 32'd0);
                    chk_eq({rq, " R5 early ack"}, "done", 32'(done), 32'd0);
                end else begin
                    @(negedge clk);
                end
            end
            chk_eq({rq, " R4 data"}, "last_n", 32'(last_n), (t == n - 1) ? 32'd0 : 32'd1);
            chk_eq({rq, " data"}, "addr", xaddr, ea);
            chk_eq({rq, " data"}, "lanes", 32'(lanes), 32'(eb));
            chk_eq({rq, " R10 data"}, "cyc_start", 32'(cyc_start), 32'd0);
            if (flip && t == 0) begin
                port8_n = ~w8n; port16_n = ~w16n; cache_ok_n = ~cn;
            end
            if (burst_m[t]) begin
                burst_n = 1'b0;
            end else begin
                ack_n = 1'b0;
                if (both_low) burst_n = 1'b0;
            end
            new_cyc = !burst_m[t];
            if (!fill) p = ((p >> k) + 32'd1) << k;
        end
        @(negedge clk);
        ack_n = 1'b1; burst_n = 1'b1;
        chk_eq({rq, " R13 end"}, "done", 32'(done), 32'd1);
        chk_eq({rq, " R13 end"}, "busy", 32'(busy), 32'd0);
        chk_eq({rq, " R3 idle"}, "last_n", 32'(last_n), 32'd1);
        @(negedge clk);
        chk_eq({rq, " R13 pulse"}, "done", 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        chk_eq("R13 reset", "busy", 32'(busy), 32'd0);
        chk_eq("R13 reset", "done", 32'(done), 32'd0);
        chk_eq("R3 reset", "last_n", 32'(last_n), 32'd1);
        chk_eq("R1 reset", "cyc_start", 32'(cyc_start), 32'd0);
    endtask

    task automatic t_single_dword();
        run_xact(32'h0000_0100, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R1 dword");
    endtask

    task automatic t_two_cycle_read();
        run_xact(32'h0000_0108, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R11 two-cycle");
    endtask

    task automatic t_fill_burst();
        run_xact(32'h0000_0204, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0, "R8 R10 fill");
    endtask

    task automatic t_fill_cut();
        run_xact(32'h0000_0304, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0, "R12 fill cut");
    endtask

    task automatic t_write_no_fill();
        run_xact(32'h0000_0400, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R9 write");
    endtask

    task automatic t_port8();
        run_xact(32'h0000_0500, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R6 port8");
    endtask

    task automatic t_port_priority();
        run_xact(32'h0000_0601, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R6 8-wins");
    endtask

    task automatic t_port16_burst();
        run_xact(32'h0000_0700, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0, "R6 R10 port16");
    endtask

    task automatic t_misaligned();
        run_xact(32'h0000_0803, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R7 misaligned");
    endtask

    task automatic t_early_ack();
        run_xact(32'h0000_0900, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, "R5 early");
    endtask

    task automatic t_reply_timing();
        run_xact(32'h0000_0A00, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, "R2 timing");
    endtask

    task automatic t_both_ready();
        run_xact(32'h0000_0B00, 3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, "R11 both-low");
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_dword();
        t_two_cycle_read();
        t_fill_burst();
        t_fill_cut();
        t_write_no_fill();
        t_port8();
        t_port_priority();
        t_port16_burst();
        t_misaligned();
        t_early_ack();
        t_reply_timing();
        t_both_ready();
        repeat (2) @(negedge clk);
        report();
        $finish;
    end

endmodule